// File: doc/BRIEF.md
# Serial Identification Code CRC Checker

This block checks a 64-bit identification code that reaches it one bit at a time, least significant bit first. The code consists of an 8-bit family byte, a 48-bit serial number and a trailing 8-bit CRC byte. A bit-serial CRC-8 engine with the polynomial x^8 + x^5 + x^4 + 1 folds in every accepted bit. The frame is accepted when the register holds zero after all 64 bits, including the stored CRC, have been shifted in. No separate comparator is used.

A controller pulses `start` before each transfer and then presents bits with `bit_valid`. The running remainder is always visible on `crc`. After the 64th accepted bit, `done` pulses for one cycle and `ok` shows the verdict. The engine keeps accumulating beyond 64 bits. The same block therefore validates longer transfers that carry a trailing CRC byte, such as a 32-byte buffer followed by its CRC. The controller then reads a zero remainder on `crc`. The block only reports. It never stalls or blocks the transfer, and the decision to go on belongs to the controller.

Top module: `id_crc_monitor`

## Requirements
- R1: A synchronous reset, or a `start` pulse, clears `crc` to 8'h00 and `done` and `ok` to 0 at the next clock edge. These are the values before the first bit.
- R2: When `start` and `bit_valid` are both high, `start` wins. The bit is discarded and `crc` reads 8'h00 afterwards.
- R3: For each accepted bit, the block forms f = crc[0] XOR bit_in. It then shifts `crc` right by one, with 0 entering bit 7, and XORs the result with 8'h8C when f is 1.
- R4: While `bit_valid` is low and `start` is low, `crc` and `ok` hold their values, the bit counter does not advance, and `done` is 0.
- R5: After the 56 bits of bytes 0x02, 0x1C, 0xB8, 0x01, 0x00, 0x00, 0x00 are fed in that byte order, each byte LSB first, `crc` reads 8'hA2.
- R6: `done` is high for exactly the one cycle that follows the clock edge that accepted the 64th bit after `start`. No further `done` occurs until the next `start`.
- R7: At that `done`, `ok` is 1 exactly when the remainder is 8'h00. `ok` then holds through idle cycles and through any further bits until the next `start` or reset.
- R8: Inverting any single bit of a valid 64-bit frame gives `ok` = 0 at `done`. Bits that arrive afterwards are still folded into `crc`.
- R9: Accumulation continues past 64 bits. A block of 32 data bytes followed by its CRC byte, 264 bits in all, leaves `crc` = 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clears the remainder, counter and verdict; wins over `bit_valid` |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit, LSB first |
| crc | output | 8 | Running CRC remainder |
| done | output | 1 | One-cycle pulse after the last bit of the identification frame |
| ok | output | 1 | Frame verdict: remainder was zero at `done` |

## Verification
The hardest situation to reach is a corrupted frame whose error still leaves a plausible-looking remainder. The verdict can only be trusted if every single-bit error position turns `ok` off. The bench walks a flipped bit through the family byte, the serial field, the stored CRC byte and both ends of the frame. It also replays a frame with idle gaps between bits, starts a frame with `start` and `bit_valid` high together, and pushes bits past the 64th. A behavioural reference model is compared against all outputs on every clock.

// File: rtl/icm_pkg.sv
package icm_pkg;
   typedef enum logic {
      ICM_LSB_FIRST = 1'b0,
      ICM_MSB_FIRST = 1'b1
   } icm_order_e;

   localparam int unsigned ICM_CRC_W          = 8;
   localparam logic [7:0]  ICM_POLY_REFLECTED = 8'h8C;
   localparam int unsigned ICM_FRAME_BITS     = 64;
endpackage

// File: rtl/icm_crc_step.sv
module icm_crc_step
   import icm_pkg::*;
#(
   parameter int unsigned    W         = ICM_CRC_W,
   parameter logic [W-1:0]   POLY_REFL = W'(ICM_POLY_REFLECTED),
   parameter icm_order_e     ORDER     = ICM_LSB_FIRST
) (
   input  logic [W-1:0] crc_q,
   input  logic         bit_in,
   output logic [W-1:0] crc_d
);
   function automatic logic [W-1:0] bit_reverse(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   localparam logic [W-1:0] POLY_NORM = bit_reverse(POLY_REFL);

   if (W < 2) begin : g_bad_width
      $error("icm_crc_step: W must be at least 2");
   end

   if (ORDER == ICM_LSB_FIRST) begin : g_lsb
      logic fb;
      assign fb = crc_q[0] ^ bit_in;
      for (genvar k = 0; k < W; k++) begin : g_tap
         if (k == W - 1) begin : g_top
            assign crc_d[k] = fb & POLY_REFL[k];
         end else begin : g_mid
            assign crc_d[k] = crc_q[k+1] ^ (fb & POLY_REFL[k]);
         end
      end
   end else begin : g_msb
      logic fb;
      assign fb = crc_q[W-1] ^ bit_in;
      for (genvar k = 0; k < W; k++) begin : g_tap
         if (k == 0) begin : g_bot
            assign crc_d[k] = fb & POLY_NORM[k];
         end else begin : g_mid
            assign crc_d[k] = crc_q[k-1] ^ (fb & POLY_NORM[k]);
         end
      end
   end
endmodule

// File: rtl/icm_bit_counter.sv
module icm_bit_counter #(
   parameter int unsigned FRAME_BITS = 64,
   localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic adv,
   output logic last
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_BITS);

   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("icm_bit_counter: FRAME_BITS must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q <= '0;
      end else if (adv && (cnt_q != FULL)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last = adv && (cnt_q == LAST_IDX);
endmodule

// File: rtl/id_crc_monitor.sv
module id_crc_monitor
   import icm_pkg::*;
#(
   parameter int unsigned  W          = ICM_CRC_W,
   parameter logic [W-1:0] POLY_REFL  = W'(ICM_POLY_REFLECTED),
   parameter icm_order_e   ORDER      = ICM_LSB_FIRST,
   parameter int unsigned  FRAME_BITS = ICM_FRAME_BITS
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         bit_valid,
   input  logic         bit_in,
   output logic [W-1:0] crc,
   output logic         done,
   output logic         ok
);
   if (FRAME_BITS <= W) begin : g_bad_len
      $error("id_crc_monitor: frame must be longer than the CRC");
   end

   logic [W-1:0] crc_q;
   logic [W-1:0] crc_d;
   logic         last_bit;
   logic         done_q;
   logic         ok_q;
   logic         accept;

   assign accept = bit_valid && !start;

   icm_crc_step #(
      .W        (W),
      .POLY_REFL(POLY_REFL),
      .ORDER    (ORDER)
   ) u_step (
      .crc_q (crc_q),
      .bit_in(bit_in),
      .crc_d (crc_d)
   );

   icm_bit_counter #(
      .FRAME_BITS(FRAME_BITS)
   ) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (start),
      .adv (accept),
      .last(last_bit)
   );

   always_ff @(posedge clk) begin
      if (rst || start) begin
         crc_q  <= '0;
         done_q <= 1'b0;
         ok_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (bit_valid) begin
            crc_q <= crc_d;
            if (last_bit) begin
               done_q <= 1'b1;
               ok_q   <= (crc_d == '0);
            end
         end
      end
   end

   assign crc  = crc_q;
   assign done = done_q;
   assign ok   = ok_q;
endmodule

// File: rtl/id_crc_monitor_props.sv
module id_crc_monitor_props #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         start,
   input logic         bit_valid,
   input logic [W-1:0] crc,
   input logic         done,
   input logic         ok
);
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
      start |=> (crc == '0) && !done && !ok); // R1

   AST_START_WINS: assert property (@(posedge clk) disable iff (rst)
      (start && bit_valid) |=> (crc == '0)); // R2

   AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (!start && !bit_valid) |=> ($stable(crc) && $stable(ok) && !done)); // R4

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R6

   AST_OK_MATCHES_RESIDUE: assert property (@(posedge clk) disable iff (rst)
      done |-> (ok == (crc == '0))); // R7

   AST_OK_STICKY: assert property (@(posedge clk) disable iff (rst)
      !start |=> (done || $stable(ok))); // R7
endmodule

bind id_crc_monitor id_crc_monitor_props #(.W(W)) u_props (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .bit_valid(bit_valid),
   .crc      (crc),
   .done     (done),
   .ok       (ok)
);

// File: tb/test_id_crc_monitor.sv
`timescale 1ns/1ps
module test_id_crc_monitor;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       bit_valid = 1'b0;
   logic       bit_in = 1'b0;
   logic [7:0] crc;
   logic       done;
   logic       ok;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [7:0] m_crc = 8'h00;
   int         m_cnt = 0;
   logic       m_done = 1'b0;
   logic       m_ok = 1'b0;

   localparam logic [55:0] ID56 = 56'h00_0000_01B8_1C02;

   always #2.5 clk = ~clk;

   id_crc_monitor i_id_crc_monitor (
      .clk(clk), .rst(rst), .start(start), .bit_valid(bit_valid),
      .bit_in(bit_in), .crc(crc), .done(done), .ok(ok)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_crc(input bit q[$]);
      int m = 0;
      foreach (q[i]) begin
         if (((m & 1) ^ int'(q[i])) != 0) m = (m >> 1) ^ 'h8C;
         else m = m >> 1;
      end
      return 8'(m);
   endfunction

   task automatic cyc(input logic r, input logic s, input logic v,
                      input logic b, input string tag);
      rst = r; start = s; bit_valid = v; bit_in = b;
      @(posedge clk);
      if (r || s) begin
         m_crc = 0; m_cnt = 0; m_done = 0; m_ok = 0;
      end else if (v) begin
         bit q[$];
         logic [7:0] nxt;
         q.push_back(b);
         nxt = m_crc;
         if ((nxt[0] ^ b) == 1'b1) nxt = (nxt >> 1) ^ 8'h8C;
         else nxt = nxt >> 1;
         m_done = (m_cnt == 63);
         if (m_done) m_ok = (nxt == 8'h00);
         m_crc = nxt;
         if (m_cnt < 64) m_cnt++;
      end else begin
         m_done = 0;
      end
      @(negedge clk);
      chk(tag, "crc", 32'(crc), 32'(m_crc));
      chk(tag, "done", 32'(done), 32'(m_done));
      chk(tag, "ok", 32'(ok), 32'(m_ok));
   endtask

   task automatic feed(input bit q[$], input bit gaps, input string tag);
      foreach (q[i]) begin
         cyc(1'b0, 1'b0, 1'b1, q[i], tag);
         if (gaps) cyc(1'b0, 1'b0, 1'b0, ~q[i], tag);
      end
   endtask

   function automatic void frame_bits(output bit q[$]);
      logic [63:0] f = {8'hA2, ID56};
      q = {};
      for (int i = 0; i < 64; i++) q.push_back(f[i]);
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      bit fr[$];
      bit part[$];
      @(negedge clk);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, "R1");
      chk("R1", "reset crc", 32'(crc), 0);
      chk("R1", "reset ok", 32'(ok), 0);

      // R2/R3/R5: start with bit_valid high, then the known code
      cyc(1'b0, 1'b1, 1'b1, 1'b1, "R2");
      chk("R2", "crc after start+valid", 32'(crc), 0);
      frame_bits(fr);
      part = fr[0:55];
      feed(part, 1'b0, "R3");
      chk("R5", "crc after 56 bits", 32'(crc), 32'h A2);
      part = fr[56:63];
      feed(part, 1'b0, "R6");
      chk("R6", "done after 64th", 32'(done), 1);
      chk("R7", "ok on clean frame", 32'(ok), 1);
      cyc(1'b0, 1'b0, 1'b0, 1'b0, "R6");
      chk("R6", "done drops", 32'(done), 0);

      // R4/R7: idle and extra bits keep the verdict
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, "R4");
      chk("R4", "crc held idle", 32'(crc), 0);
      part = {1'b1, 1'b0, 1'b1};
      feed(part, 1'b0, "R7");
      chk("R7", "ok held after extra bits", 32'(ok), 1);
      chk("R6", "no second done", 32'(done), 0);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, "R1");
      chk("R1", "start clears ok", 32'(ok), 0);

      // R4: frame with idle gaps between bits
      feed(fr, 1'b1, "R4");
      chk("R4", "gapped frame ok", 32'(ok), 1);

      // R8: single-bit errors
      foreach (fr[j]) begin
         if (j == 0 || j == 7 || j == 17 || j == 40 || j == 55 || j == 58 || j == 63) begin
            bit bad[$];
            bad = fr;
            bad[j] = ~bad[j];
            cyc(1'b0, 1'b1, 1'b0, 1'b0, "R8");
            feed(bad, 1'b0, "R8");
            chk("R8", $sformatf("ok with bit %0d flipped", j), 32'(ok), 0);
            chk("R8", "done with error", 32'(done), 1);
         end
      end
      part = {1'b1, 1'b1};
      feed(part, 1'b0, "R8");

      // R9: 32-byte block plus CRC byte
      begin
         bit blk[$];
         logic [7:0] c;
         blk = {};
         for (int by = 0; by < 32; by++) begin
            logic [7:0] d = 8'(by * 37 + 5);
            for (int k = 0; k < 8; k++) blk.push_back(d[k]);
         end
         c = ref_crc(blk);
         for (int k = 0; k < 8; k++) blk.push_back(c[k]);
         cyc(1'b0, 1'b1, 1'b0, 1'b0, "R9");
         feed(blk, 1'b0, "R9");
         chk("R9", "block residue", 32'(crc), 0);
      end

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule